// File: doc/BRIEF.md
# Synchronous burst SRAM controller

This block is a clock-exact front end for a pipelined synchronous burst SRAM, with its own small storage array. Each word is 36 bits wide: four 8-bit byte lanes, and each lane has its own parity bit. On every rising clock edge the block samples two competing active-low address strobes, three chip enables, per-lane write enables, an active-low burst-advance input and a static burst-order select. From these it loads a start address, steps through a four-beat burst, performs reads and lane-masked writes, and returns read data through an output pipeline register.

The two strobes follow different rules. The processor strobe needs the primary enable and always reads. The controller strobe can read or write, and it powers the device down when the primary enable is inactive. Power-down is reported on a flag. While it is set, the output stays quiet and the block ignores all activity until a qualified strobe is accepted.

Top module: `sbsram_core`

## Requirements
- R1: After reset, `rdata_oe` is 0, `rdata` is all zeros, `pwr_down` is 0, and no burst is active, so an advance has no effect.
- R2: When `proc_stb_n` is low and `sel_n` is low, with `sel_hi` high and `sel_lo_n` low, the block loads `addr_in` and reads that word. This happens whatever `lane_we_n` and `ctrl_stb_n` are doing. Any burst in progress is cancelled. The word appears on `rdata`, with `rdata_oe` high, in the cycle after the second rising edge that follows the strobe edge.
- R3: When `proc_stb_n` is low while `sel_n` is high, and `ctrl_stb_n` and `adv_n` are both high, nothing happens: no access takes place and the current burst position is kept.
- R4: When `proc_stb_n` is low and `sel_n` is low, but `sel_hi` is low or `sel_lo_n` is high, the block enters power-down (`pwr_down` set) and performs no read.
- R5: When `ctrl_stb_n` is low with `sel_n` low, and the processor strobe is not accepted, the block loads `addr_in`. If any bit of `lane_we_n` is low the cycle is a write; otherwise it is a read.
- R6: When `ctrl_stb_n` is low while `sel_n` is high, the block enters power-down.
- R7: Lane i holds data bits [8i+7:8i] and parity bit 32+i. A write updates lane i and its parity bit only when `lane_we_n[i]` is 0. All other lanes keep their contents.
- R8: With `order_sel` at 0 (linear order), beat k of a burst uses the start address with its two low bits replaced by (start low bits + k) mod 4.
- R9: With `order_sel` at 1 (interleaved order), beat k uses the start address with its two low bits XORed with k.
- R10: A low `adv_n` with neither strobe asserted moves an active burst one beat forward. The beat is a read or a write, matching the burst's opening access. A write beat takes the current `wdata` and `lane_we_n`. After the fourth beat, the next advance returns to the start address.
- R11: In power-down, `rdata_oe` stays low, advances and writes are ignored, and reads already in flight are discarded. This lasts until a strobe is accepted under R2 or R5.
- R12: Whenever `rdata_oe` is low, `rdata` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| order_sel | input | 1 | Burst order: 0 linear, 1 interleaved; held static |
| proc_stb_n | input | 1 | Processor address strobe, active low, read only |
| ctrl_stb_n | input | 1 | Controller address strobe, active low, read or write |
| sel_n | input | 1 | Primary chip enable, active low |
| sel_hi | input | 1 | Secondary chip enable, active high |
| sel_lo_n | input | 1 | Secondary chip enable, active low |
| adv_n | input | 1 | Burst advance, active low |
| lane_we_n | input | 4 | Per-lane write enables, active low |
| addr_in | input | ADDR_W (6) | External word address |
| wdata | input | 36 | Write data: four 8-bit lanes plus four parity bits |
| rdata | output | 36 | Registered read data, zero when not valid |
| rdata_oe | output | 1 | High while `rdata` carries a valid read |
| pwr_down | output | 1 | Power-down flag |

## Verification
The stimulus first writes a four-beat burst starting at a low-bits-zero address. It then overwrites two alternate lanes of one word. Comparing the read-back against both the original data and an all-lanes update shows whether the lane masking and the parity placement are correct.

Reads are opened three ways: by the processor strobe with every write enable low and the other strobe asserted, which separates the priority and always-read rule from a write; by the controller strobe at a mid-word start address, which exposes a linear wrap that skips the carry; and, after a reset with the order select high, at an odd start, which separates interleaved order from linear order.

An ignored processor strobe issued in the middle of a burst, followed by an advance, shows whether the burst position survived. Each of the three ways into power-down is followed by an advance. One of these advances belongs to a write burst and aims at a word whose contents are known. This shows whether power-down suppresses both output and stores.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

    localparam int LANES  = 4;
    localparam int LANE_W = 8;
    localparam int DATA_W = LANES * LANE_W;
    localparam int WORD_W = DATA_W + LANES;
    localparam int BEAT_W = 2;

    // Decoded cycle type, computed from the sampled pins.
    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_RD,
        CMD_WR,
        CMD_ADV,
        CMD_SLEEP
    } cmd_e;

    // Control part of a registered access.
    typedef struct packed {
        logic             valid;
        logic             wr;
        logic [LANES-1:0] lane_en;
    } acc_t;

    // Low address bits of beat number 'beat' for a burst that starts at 'start'.
    function automatic logic [BEAT_W-1:0] beat_low(
        input logic [BEAT_W-1:0] start,
        input logic [BEAT_W-1:0] beat,
        input logic              interleave
    );
        return interleave ? (start ^ beat) : (start + beat);
    endfunction

    // Bit mask covering every enabled lane together with its parity bit.
    function automatic logic [WORD_W-1:0] lane_mask(input logic [LANES-1:0] en);
        logic [WORD_W-1:0] m;
        m = '0;
        for (int i = 0; i < LANES; i++) begin
            if (en[i]) begin
                m[i*LANE_W +: LANE_W] = '1;
                m[DATA_W + i]         = 1'b1;
            end
        end
        return m;
    endfunction

endpackage

// File: rtl/sbsram_decode.sv
module sbsram_decode
    import sbsram_pkg::*;
(
    input  logic             proc_stb_n,
    input  logic             ctrl_stb_n,
    input  logic             sel_n,
    input  logic             sel_hi,
    input  logic             sel_lo_n,
    input  logic             adv_n,
    input  logic [LANES-1:0] lane_we_n,
    output cmd_e             cmd
);

    logic proc_take;
    logic sec_ok;
    logic any_lane;

    assign proc_take = !proc_stb_n && !sel_n;
    assign sec_ok    = sel_hi && !sel_lo_n;
    assign any_lane  = (lane_we_n != '1);

    // The processor strobe wins; the controller strobe is looked at next;
    // advance only counts when no strobe is present.
    always_comb begin
        if (proc_take) begin
            cmd = sec_ok ? CMD_RD : CMD_SLEEP;
        end else if (!ctrl_stb_n) begin
            if (sel_n) cmd = CMD_SLEEP;
            else       cmd = any_lane ? CMD_WR : CMD_RD;
        end else if (!adv_n) begin
            cmd = CMD_ADV;
        end else begin
            cmd = CMD_NONE;
        end
    end

endmodule

// File: rtl/sbsram_burst.sv
module sbsram_burst
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  cmd_e              cmd,
    input  logic              order_sel,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [WORD_W-1:0] wdata,
    input  logic [LANES-1:0]  lane_en,
    output acc_t              acc,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [WORD_W-1:0] acc_wdata,
    output logic              pwr_down
);

    localparam int HI_W = ADDR_W - BEAT_W;

    logic [ADDR_W-1:0] base_q;
    logic [BEAT_W-1:0] beat_q;
    logic [BEAT_W-1:0] beat_nx;
    logic              active_q;
    logic              wr_q;

    assign beat_nx = beat_q + BEAT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q    <= '0;
            beat_q    <= '0;
            active_q  <= 1'b0;
            wr_q      <= 1'b0;
            pwr_down  <= 1'b0;
            acc       <= '0;
            acc_addr  <= '0;
            acc_wdata <= '0;
        end else begin
            acc_wdata <= wdata;
            unique case (cmd)
                CMD_RD, CMD_WR: begin
                    base_q      <= addr_in;
                    beat_q      <= '0;
                    active_q    <= 1'b1;
                    wr_q        <= (cmd == CMD_WR);
                    pwr_down    <= 1'b0;
                    acc.valid   <= 1'b1;
                    acc.wr      <= (cmd == CMD_WR);
                    acc.lane_en <= lane_en;
                    acc_addr    <= addr_in;
                end
                CMD_ADV: begin
                    if (active_q) begin
                        beat_q      <= beat_nx;
                        acc.valid   <= 1'b1;
                        acc.wr      <= wr_q;
                        acc.lane_en <= lane_en;
                        acc_addr    <= {base_q[ADDR_W-1 -: HI_W],
                                        beat_low(base_q[BEAT_W-1:0], beat_nx, order_sel)};
                    end else begin
                        acc.valid <= 1'b0;
                    end
                end
                CMD_SLEEP: begin
                    active_q  <= 1'b0;
                    pwr_down  <= 1'b1;
                    acc.valid <= 1'b0;
                end
                default: begin
                    acc.valid <= 1'b0;
                end
            endcase
        end
    end

    // One beat forward per accepted advance (R10)
    assert_adv_step_R10: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_ADV && active_q) |=> (beat_q == $past(beat_q) + BEAT_W'(1)))
        else $error("advance did not move the burst by one beat");

endmodule

// File: rtl/sbsram_array.sv
module sbsram_array
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  acc_t              acc,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [WORD_W-1:0] acc_wdata,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];
    logic [WORD_W-1:0] wmask;

    assign wmask = lane_mask(acc.lane_en);

    // Storage is not reset: its contents persist across reset.
    always_ff @(posedge clk) begin
        if (acc.valid && acc.wr) begin
            mem[acc_addr] <= (mem[acc_addr] & ~wmask) | (acc_wdata & wmask);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= acc.valid && !acc.wr;
            rd_data  <= mem[acc_addr];
        end
    end

    // A flushed cycle leaves no read behind (R11)
    assert_flush_drop_R11: assert property (@(posedge clk) disable iff (rst)
        flush |=> !rd_valid)
        else $error("read survived a power-down flush");

endmodule

// File: rtl/sbsram_outpipe.sv
module sbsram_outpipe
    import sbsram_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              rd_valid,
    input  logic [WORD_W-1:0] rd_data,
    output logic [WORD_W-1:0] rdata,
    output logic              rdata_oe
);

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rdata    <= '0;
            rdata_oe <= 1'b0;
        end else begin
            rdata    <= rd_valid ? rd_data : '0;
            rdata_oe <= rd_valid;
        end
    end

    // Idle output is all zeros (R12)
    assert_quiet_R12: assert property (@(posedge clk) disable iff (rst)
        !rdata_oe |-> (rdata == '0))
        else $error("rdata not zero while output disabled");

endmodule

// File: rtl/sbsram_core.sv
module sbsram_core
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              order_sel,
    input  logic              proc_stb_n,
    input  logic              ctrl_stb_n,
    input  logic              sel_n,
    input  logic              sel_hi,
    input  logic              sel_lo_n,
    input  logic              adv_n,
    input  logic [LANES-1:0]  lane_we_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic              rdata_oe,
    output logic              pwr_down
);

    cmd_e              cmd;
    logic              flush;
    acc_t              acc;
    logic [ADDR_W-1:0] acc_addr;
    logic [WORD_W-1:0] acc_wdata;
    logic              rd_valid;
    logic [WORD_W-1:0] rd_data;

    assign flush = (cmd == CMD_SLEEP);

    sbsram_decode u_decode (
        .proc_stb_n (proc_stb_n),
        .ctrl_stb_n (ctrl_stb_n),
        .sel_n      (sel_n),
        .sel_hi     (sel_hi),
        .sel_lo_n   (sel_lo_n),
        .adv_n      (adv_n),
        .lane_we_n  (lane_we_n),
        .cmd        (cmd)
    );

    sbsram_burst #(.ADDR_W(ADDR_W)) u_burst (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .order_sel (order_sel),
        .addr_in   (addr_in),
        .wdata     (wdata),
        .lane_en   (~lane_we_n),
        .acc       (acc),
        .acc_addr  (acc_addr),
        .acc_wdata (acc_wdata),
        .pwr_down  (pwr_down)
    );

    sbsram_array #(.ADDR_W(ADDR_W)) u_array (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .acc       (acc),
        .acc_addr  (acc_addr),
        .acc_wdata (acc_wdata),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

    sbsram_outpipe u_out (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .rd_valid (rd_valid),
        .rd_data  (rd_data),
        .rdata    (rdata),
        .rdata_oe (rdata_oe)
    );

    // Accepted processor strobe registers a read of the pin address (R2)
    assert_rd_load_R2: assert property (@(posedge clk) disable iff (rst)
        (!proc_stb_n && !sel_n && sel_hi && !sel_lo_n)
        |=> (acc.valid && !acc.wr && acc_addr == $past(addr_in)))
        else $error("processor strobe did not load a read");

    // Valid output always traces back to a read registered two edges earlier (R2)
    assert_rd_origin_R2: assert property (@(posedge clk) disable iff (rst)
        rdata_oe |-> $past(acc.valid && !acc.wr, 2))
        else $error("output valid without a matching read");

    // Unqualified processor strobe changes nothing (R3)
    assert_ign_R3: assert property (@(posedge clk) disable iff (rst)
        (!proc_stb_n && sel_n && ctrl_stb_n && adv_n)
        |=> (!acc.valid && $stable(pwr_down)))
        else $error("ignored processor strobe had an effect");

    // Processor strobe with a secondary enable off powers down (R4)
    assert_proc_pd_R4: assert property (@(posedge clk) disable iff (rst)
        (!proc_stb_n && !sel_n && (!sel_hi || sel_lo_n)) |=> (pwr_down && !acc.valid))
        else $error("processor strobe failed to power down");

    // Controller strobe with primary enable on: write iff any lane enabled (R5)
    assert_ctrl_op_R5: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_stb_n && !sel_n && proc_stb_n)
        |=> (acc.valid && acc.wr == $past(lane_we_n != '1)))
        else $error("controller strobe picked the wrong access");

    // Controller strobe with primary enable off powers down (R6)
    assert_ctrl_pd_R6: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_stb_n && sel_n) |=> pwr_down)
        else $error("controller strobe failed to power down");

    // Output stays disabled throughout power-down (R11)
    assert_pd_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        pwr_down |-> (!rdata_oe && !acc.valid))
        else $error("activity during power-down");

endmodule

// File: tb/sbsram_core_tb_top.sv
`timescale 1ns/1ps
module sbsram_core_tb_top;

    typedef enum logic [2:0] {
        K_IDLE, K_PRD, K_CRW, K_ADV, K_PIGN, K_CPD, K_PPH, K_PPL
    } kind_e;

    // Expected values are observed at the falling edge before the row drives.
    // exp == 0 means rdata_oe expected low.
    typedef struct packed {
        kind_e       kind;
        logic [3:0]  lanes_n;
        logic [5:0]  addr;
        logic [35:0] wd;
        logic [35:0] exp;
        logic        exp_pd;
        logic [3:0]  req;
    } row_t;

    localparam int NROWS = 48;
    localparam row_t TBL [NROWS] = '{
        '{K_CRW,  4'b0000, 6'd8,  36'hA_11223344, 36'h0,           1'b0, 4'd5},  // R5 write opens burst
        '{K_ADV,  4'b0000, 6'd0,  36'h0_55667788, 36'h0,           1'b0, 4'd10}, // R10 write beat 9
        '{K_ADV,  4'b0000, 6'd0,  36'h3_CCDDEEFF, 36'h0,           1'b0, 4'd10}, // R10 write beat 10
        '{K_ADV,  4'b0000, 6'd0,  36'h6_99AABBCC, 36'h0,           1'b0, 4'd10}, // R10 write beat 11
        '{K_CRW,  4'b1010, 6'd9,  36'hF_FFFFFFFF, 36'h0,           1'b0, 4'd7},  // R7 lanes 0,2
        '{K_PRD,  4'b0000, 6'd8,  36'h0,          36'h0,           1'b0, 4'd2},  // R2 read despite enables
        '{K_ADV,  4'b0000, 6'd0,  36'h0,          36'h0,           1'b0, 4'd10},
        '{K_ADV,  4'b0000, 6'd0,  36'h0,          36'h0,           1'b0, 4'd10},
        '{K_ADV,  4'b0000, 6'd0,  36'h0,          36'hA_11223344,  1'b0, 4'd2},  // R2 word 8
        '{K_ADV,  4'b0000, 6'd0,  36'h0,          36'h5_55FF77FF,  1'b0, 4'd7},  // R7 merged word 9
        '{K_IDLE, 4'b1111, 6'd0,  36'h0,          36'h3_CCDDEEFF,  1'b0, 4'd8},  // R8 word 10
        '{K_IDLE, 4'b1111, 6'd0,  36'h0,          36'h6_99AABBCC,  1'b0, 4'd8},  // R8 word 11
        '{K_IDLE, 4'b1111, 6'd0,  36'h0,          36'hA_11223344,  1'b0, 4'd10}, // R10 wrap
        '{K_IDLE, 4'b1111, 6'd0,  36'h0,          36'h0,           1'b0, 4'd12}, // R12 idle
        '{K_CRW,  4'b1111, 6'd10, 36'h0,          36'h0,           1'b0, 4'd5},  // R5 read at 10
        '{K_ADV,  4'b1111, 6'd0,  36'h0,          36'h0,           1'b0, 4'd8},
        '{K_ADV,  4'b1111, 6'd0,  36'h0,          36'h0,           1'b0, 4'd8},
        '{K_ADV,  4'b1111, 6'd0,  36'h0,          36'h3_CCDDEEFF,  1'b0, 4'd5},  // R5 word 10
        '{K_PIGN, 4'b1111, 6'd0,  36'h0,          36'h6_99AABBCC,  1'b0, 4'd8},  // R8 11
        '{K_ADV,  4'b1111, 6'd0,  36'h0,          36'hA_11223344,  1'b0, 4'd8},  // R8 wrap to 8
        '{K_IDLE, 4'b1111, 6'd0,  36'h0,          36'h5_55FF77FF,  1'b0, 4'd8},  // R8 9
        '{K_IDLE, 4'b1111, 6'd0,  36'h0,          36'h0,           1'b0, 4'd3},  // R3 no access
        '{K_IDLE, 4'b1111, 6'd0,  36'h0,          36'h3_CCDDEEFF,  1'b0, 4'd3},  // R3 burst kept
        '{K_CPD,  4'b1111, 6'd0,  36'h0,          36'h0,           1'b0, 4'd6},
        '{K_ADV,  4'b1111, 6'd0,  36'h0,          36'h0,           1'b1, 4'd6},  // R6 asleep
        '{K_IDLE, 4'b1111, 6'd0,  36'h0,          36'h0,           1'b1, 4'd11},
        '{K_IDLE, 4'b1111, 6'd0,  36'h0,          36'h0,           1'b1, 4'd11},
        '{K_PRD,  4'b1111, 6'd11, 36'h0,          36'h0,           1'b1, 4'd11}, // R11 adv ignored
        '{K_IDLE, 4'b1111, 6'd0,  36'h0,          36'h0,           1'b0, 4'd11}, // R11 woken
        '{K_IDLE, 4'b1111, 6'd0,  36'h0,          36'h0,           1'b0, 4'd2},
        '{K_IDLE, 4'b1111, 6'd0,  36'h0,          36'h6_99AABBCC,  1'b0, 4'd2},  // R2 latency
        '{K_PPH,  4'b1111, 6'd8,  36'h0,          36'h0,           1'b0, 4'd4},
        '{K_ADV,  4'b1111, 6'd0,  36'h0,          36'h0,           1'b1, 4'd4},  // R4 asleep
        '{K_IDLE, 4'b1111, 6'd0,  36'h0,          36'h0,           1'b1, 4'd4},
        '{K_IDLE, 4'b1111, 6'd0,  36'h0,          36'h0,           1'b1, 4'd4},  // R4 no read
        '{K_IDLE, 4'b1111, 6'd0,  36'h0,          36'h0,           1'b1, 4'd11}, // R11 adv ignored
        '{K_CRW,  4'b0000, 6'd13, 36'h2_0A0B0C0D, 36'h0,           1'b1, 4'd11},
        '{K_CRW,  4'b0000, 6'd12, 36'h1_01020304, 36'h0,           1'b0, 4'd5},
        '{K_PPL,  4'b1111, 6'd0,  36'h0,          36'h0,           1'b0, 4'd4},
        '{K_ADV,  4'b0000, 6'd0,  36'hE_EEEEEEEE, 36'h0,           1'b1, 4'd4},  // R4 second enable
        '{K_CRW,  4'b1111, 6'd13, 36'h0,          36'h0,           1'b1, 4'd11},
        '{K_IDLE, 4'b1111, 6'd0,  36'h0,          36'h0,           1'b0, 4'd11},
        '{K_IDLE, 4'b1111, 6'd0,  36'h0,          36'h0,           1'b0, 4'd11},
        '{K_IDLE, 4'b1111, 6'd0,  36'h0,          36'h2_0A0B0C0D,  1'b0, 4'd11}, // R11 write dropped
        '{K_CRW,  4'b1111, 6'd12, 36'h0,          36'h0,           1'b0, 4'd5},
        '{K_IDLE, 4'b1111, 6'd0,  36'h0,          36'h0,           1'b0, 4'd5},
        '{K_IDLE, 4'b1111, 6'd0,  36'h0,          36'h0,           1'b0, 4'd5},
        '{K_IDLE, 4'b1111, 6'd0,  36'h0,          36'h1_01020304,  1'b0, 4'd5}   // R5 write held
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        order_sel;
    logic        proc_stb_n, ctrl_stb_n, sel_n, sel_hi, sel_lo_n, adv_n;
    logic [3:0]  lane_we_n;
    logic [5:0]  addr_in;
    logic [35:0] wdata;
    logic [35:0] rdata;
    logic        rdata_oe;
    logic        pwr_down;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    sbsram_core #(.ADDR_W(6)) dut_i (
        .clk(clk), .rst(rst), .order_sel(order_sel),
        .proc_stb_n(proc_stb_n), .ctrl_stb_n(ctrl_stb_n),
        .sel_n(sel_n), .sel_hi(sel_hi), .sel_lo_n(sel_lo_n),
        .adv_n(adv_n), .lane_we_n(lane_we_n), .addr_in(addr_in),
        .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe), .pwr_down(pwr_down)
    );

    task automatic drive(input row_t r);
        proc_stb_n = 1'b1; ctrl_stb_n = 1'b1; sel_n = 1'b0;
        sel_hi = 1'b1; sel_lo_n = 1'b0; adv_n = 1'b1;
        lane_we_n = r.lanes_n; addr_in = r.addr; wdata = r.wd;
        case (r.kind)
            K_PRD:   begin proc_stb_n = 1'b0; ctrl_stb_n = 1'b0; end
            K_CRW:   ctrl_stb_n = 1'b0;
            K_ADV:   adv_n = 1'b0;
            K_PIGN:  begin proc_stb_n = 1'b0; sel_n = 1'b1; end
            K_CPD:   begin ctrl_stb_n = 1'b0; sel_n = 1'b1; end
            K_PPH:   begin proc_stb_n = 1'b0; sel_hi = 1'b0; end
            K_PPL:   begin proc_stb_n = 1'b0; sel_lo_n = 1'b1; end
            default: ;
        endcase
    endtask

    task automatic check(input int req, input logic [35:0] exp, input logic exp_pd);
        logic exp_oe;
        exp_oe = (exp != '0);
        checks++;
        if (rdata !== exp || rdata_oe !== exp_oe || pwr_down !== exp_pd) begin
            fails++;
            $display("FAIL R%0d: rdata=%h oe=%b pd=%b expected rdata=%h oe=%b pd=%b",
                     req, rdata, rdata_oe, pwr_down, exp, exp_oe, exp_pd);
        end
    endtask

    task automatic run_row(input row_t r);
        @(negedge clk);
        check(int'(r.req), r.exp, r.exp_pd);
        drive(r);
    endtask

    task automatic do_reset(input logic order);
        @(negedge clk);
        rst = 1'b1;
        order_sel = order;
        drive('{K_IDLE, 4'b1111, 6'd0, 36'h0, 36'h0, 1'b0, 4'd1});
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        rst = 1'b1;
        do_reset(1'b0);
        // R1: reset state, then an advance with no burst open does nothing
        run_row('{K_ADV,  4'b0000, 6'd0, 36'h0, 36'h0, 1'b0, 4'd1});
        run_row('{K_IDLE, 4'b1111, 6'd0, 36'h0, 36'h0, 1'b0, 4'd1});
        run_row('{K_IDLE, 4'b1111, 6'd0, 36'h0, 36'h0, 1'b0, 4'd1});
        run_row('{K_IDLE, 4'b1111, 6'd0, 36'h0, 36'h0, 1'b0, 4'd1});

        for (int i = 0; i < NROWS; i++) run_row(TBL[i]);

        // R9: interleaved order from start 9 reads 9, 8, 11, 10
        do_reset(1'b1);
        run_row('{K_PRD,  4'b1111, 6'd9, 36'h0, 36'h0,          1'b0, 4'd1});
        run_row('{K_ADV,  4'b1111, 6'd0, 36'h0, 36'h0,          1'b0, 4'd9});
        run_row('{K_ADV,  4'b1111, 6'd0, 36'h0, 36'h0,          1'b0, 4'd9});
        run_row('{K_ADV,  4'b1111, 6'd0, 36'h0, 36'h5_55FF77FF, 1'b0, 4'd9});
        run_row('{K_IDLE, 4'b1111, 6'd0, 36'h0, 36'hA_11223344, 1'b0, 4'd9});
        run_row('{K_IDLE, 4'b1111, 6'd0, 36'h0, 36'h6_99AABBCC, 1'b0, 4'd9});
        run_row('{K_IDLE, 4'b1111, 6'd0, 36'h0, 36'h3_CCDDEEFF, 1'b0, 4'd9});
        run_row('{K_IDLE, 4'b1111, 6'd0, 36'h0, 36'h0,          1'b0, 4'd12});

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

endmodule